// File: doc/BRIEF.md
# Control Register Access Gate

This block decides, in the same cycle as its inputs, whether an instruction may read or write a given 12-bit control/status register address. It takes the address, the hart's current privilege encoding, a flag that says whether the access writes, and the status bit that traps supervisor access to the address-translation register. It returns a permit/deny pair and, for a permitted access, a compact index that names which implemented register was hit.

The decision is the AND of three independent verdicts. The first is an explicit table of implemented addresses, where some spans exist only for machine mode and others for both machine and supervisor mode. The second comes from fields carried in the address itself: a two-bit access-type field, in which one code marks the register read-only, and a two-bit minimum-privilege field. The third is the translation guard. The register file downstream uses the index to steer its read and write enables. It never sees a select for a denied access.

Top module: `csr_gate`

## Requirements
- R1: When address bits [11:10] equal 2'b11 the register is read-only, and any access with the write flag set is denied. A read of the same address is judged only by the other rules.
- R2: Address bits [9:8] hold a minimum privilege. An access is permitted only if the current privilege code, compared unsigned, is at least that value.
- R3: Addresses 0xF11..0xF14, 0x300..0x306 and 0x340..0x344 are implemented for privilege code 2'b11 (machine) only.
- R4: Addresses 0x100, 0x102..0x106, 0x140..0x144 and 0x180 are implemented for privilege codes 2'b11 (machine) and 2'b01 (supervisor).
- R5: Every address outside the spans of R3 and R4 is denied at every privilege and for both reads and writes.
- R6: An access to 0x180 at privilege 2'b01 is denied while the translation-trap input is 1. Machine access to 0x180 is not affected by that input.
- R7: Privilege code 2'b00 (user) and the reserved code 2'b10 are denied for every address.
- R8: The deny output is always the inverse of the permit output, and both are settled in the same cycle as the inputs, with no register in the path.
- R9: For a permitted access the select-valid output is 1, and the index is: 0xF11..0xF14 -> 0..3, 0x300..0x306 -> 4..10, 0x340..0x344 -> 11..15, 0x100 -> 16, 0x102..0x106 -> 17..21, 0x140..0x144 -> 22..26, 0x180 -> 27. For a denied access select-valid is 0 and the index is 0.
- R10: The translation-trap input has no effect on any address other than 0x180.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| csr_addr | input | 12 | Address of the register being accessed |
| cur_priv | input | 2 | Current privilege code (00 user, 01 supervisor, 11 machine) |
| is_write | input | 1 | 1 when the access modifies the register |
| xlat_trap | input | 1 | Status bit that traps supervisor access to 0x180 |
| acc_ok | output | 1 | Access permitted |
| acc_illegal | output | 1 | Access denied, raise illegal-instruction |
| sel_vld | output | 1 | Register index is valid |
| sel_idx | output | 5 | Index of the matched implemented register |

## Verification
Several denial causes can hold for the same access at once. A supervisor write to a read-only machine address fails on access type, on privilege floor and on the table together. A supervisor access to 0x180 with the trap bit set can overlap with a write. The bench sweeps the full address space under every privilege code and both write states, with the trap bit toggled across the sweep, and adds directed cases where two rules collide. Each result is judged against a model built from the requirement lists. A collision passes only when the access is denied and no select leaks out.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    localparam int ADDR_W  = 12;
    localparam int PRIV_W  = 2;
    localparam int N_SPAN  = 7;
    localparam int IDX_W   = 5;

    typedef enum logic [PRIV_W-1:0] {
        PRV_USER  = 2'b00,
        PRV_SUPER = 2'b01,
        PRV_RSVD  = 2'b10,
        PRV_MACH  = 2'b11
    } priv_e;

    localparam logic [1:0]        RO_CODE   = 2'b11;
    localparam logic [ADDR_W-1:0] XLAT_ADDR = 12'h180;

    // contiguous span of implemented addresses
    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic              mach_only;
    } span_t;

    // result of the table lookup
    typedef struct packed {
        logic             hit;
        logic             mach_only;
        logic [IDX_W-1:0] idx;
    } lookup_t;

    // three independent verdicts, all must be 1 to permit
    typedef struct packed {
        logic defined_ok;
        logic field_ok;
        logic xlat_ok;
    } verdict_t;

    // span table, ordered so that the index runs machine spans first
    function automatic span_t span_at(input int i);
        span_t s;
        case (i)
            0:       s = '{lo: 12'hF11, hi: 12'hF14, mach_only: 1'b1};
            1:       s = '{lo: 12'h300, hi: 12'h306, mach_only: 1'b1};
            2:       s = '{lo: 12'h340, hi: 12'h344, mach_only: 1'b1};
            3:       s = '{lo: 12'h100, hi: 12'h100, mach_only: 1'b0};
            4:       s = '{lo: 12'h102, hi: 12'h106, mach_only: 1'b0};
            5:       s = '{lo: 12'h140, hi: 12'h144, mach_only: 1'b0};
            default: s = '{lo: 12'h180, hi: 12'h180, mach_only: 1'b0};
        endcase
        return s;
    endfunction

    // first index of span i: sum of the sizes of the spans before it
    function automatic logic [IDX_W-1:0] span_base(input int i);
        int acc;
        span_t s;
        acc = 0;
        for (int k = 0; k < i; k++) begin
            s   = span_at(k);
            acc = acc + int'(s.hi - s.lo) + 1;
        end
        return IDX_W'(acc);
    endfunction

endpackage

// File: rtl/csr_span_lookup.sv
module csr_span_lookup
    import csr_gate_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = N_SPAN,
    parameter int IW = IDX_W
) (
    input  logic [AW-1:0] addr,
    output lookup_t       found
);
    logic [NS-1:0] hit_v;
    logic [NS-1:0] mach_v;
    logic [IW-1:0] idx_v [NS];

    for (genvar g = 0; g < NS; g++) begin : g_span
        localparam span_t       SP   = span_at(g);
        localparam logic [IW-1:0] BASE = span_base(g);
        logic [AW-1:0] diff;
        always_comb begin
            diff      = addr - SP.lo;
            hit_v[g]  = (addr >= SP.lo) && (addr <= SP.hi);
            mach_v[g] = SP.mach_only;
            idx_v[g]  = hit_v[g] ? (BASE + diff[IW-1:0]) : '0;
        end
    end

    // spans never overlap, so an OR merge is exact
    always_comb begin
        found = '0;
        for (int k = 0; k < NS; k++) begin
            found.hit       = found.hit | hit_v[k];
            found.mach_only = found.mach_only | (hit_v[k] & mach_v[k]);
            found.idx       = found.idx | idx_v[k];
        end
    end
endmodule

// File: rtl/csr_field_check.sv
module csr_field_check
    import csr_gate_pkg::*;
#(
    parameter int PW = PRIV_W
) (
    input  logic [1:0]    acc_type,
    input  logic [PW-1:0] min_priv,
    input  logic [PW-1:0] cur_priv,
    input  logic          is_write,
    output logic          field_ok
);
    logic ro_block;
    logic priv_ok;

    always_comb begin
        ro_block = is_write && (acc_type == RO_CODE);
        priv_ok  = cur_priv >= min_priv;
        field_ok = !ro_block && priv_ok;
    end
endmodule

// File: rtl/csr_xlat_guard.sv
module csr_xlat_guard
    import csr_gate_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PRIV_W
) (
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] cur_priv,
    input  logic          xlat_trap,
    output logic          xlat_ok
);
    always_comb begin
        xlat_ok = !((addr == XLAT_ADDR) &&
                    (priv_e'(cur_priv) == PRV_SUPER) &&
                    xlat_trap);
    end
endmodule

// File: rtl/csr_gate.sv
module csr_gate
    import csr_gate_pkg::*;
(
    input  logic [11:0] csr_addr,
    input  logic [1:0]  cur_priv,
    input  logic        is_write,
    input  logic        xlat_trap,
    output logic        acc_ok,
    output logic        acc_illegal,
    output logic        sel_vld,
    output logic [4:0]  sel_idx
);
    lookup_t  found;
    verdict_t vd;
    priv_e    prv;

    csr_span_lookup #(.AW(ADDR_W), .NS(N_SPAN), .IW(IDX_W)) i_lookup (
        .addr  (csr_addr),
        .found (found)
    );

    csr_field_check #(.PW(PRIV_W)) i_field (
        .acc_type (csr_addr[11:10]),
        .min_priv (csr_addr[9:8]),
        .cur_priv (cur_priv),
        .is_write (is_write),
        .field_ok (vd.field_ok)
    );

    csr_xlat_guard #(.AW(ADDR_W), .PW(PRIV_W)) i_xlat (
        .addr      (csr_addr),
        .cur_priv  (cur_priv),
        .xlat_trap (xlat_trap),
        .xlat_ok   (vd.xlat_ok)
    );

    always_comb begin
        prv = priv_e'(cur_priv);
        if (found.mach_only)
            vd.defined_ok = found.hit && (prv == PRV_MACH);
        else
            vd.defined_ok = found.hit && ((prv == PRV_MACH) || (prv == PRV_SUPER));
        acc_ok      = &vd;
        acc_illegal = !acc_ok;
        sel_vld     = acc_ok;
        sel_idx     = acc_ok ? found.idx : '0;
    end
endmodule

// File: rtl/csr_gate_chk.sv
module csr_gate_chk (
    input logic [11:0] csr_addr,
    input logic [1:0]  cur_priv,
    input logic        is_write,
    input logic        xlat_trap,
    input logic        acc_ok,
    input logic        acc_illegal,
    input logic        sel_vld,
    input logic [4:0]  sel_idx
);
    always_comb begin
        AST_RO_WRITE_DENIED: assert (!(is_write && csr_addr[11:10] == 2'b11) || !acc_ok); // R1
        AST_PRIV_FLOOR: assert (!acc_ok || (cur_priv >= csr_addr[9:8])); // R2
        AST_LOW_PRIV_DENIED: assert (!(cur_priv == 2'b00 || cur_priv == 2'b10) || !acc_ok); // R7
        AST_XLAT_TRAP: assert (!(csr_addr == 12'h180 && cur_priv == 2'b01 && xlat_trap) || !acc_ok); // R6
        AST_VERDICT_EXCLUSIVE: assert (acc_ok != acc_illegal); // R8
        AST_SEL_TRACKS_OK: assert (sel_vld == acc_ok); // R9
        AST_SEL_IDLE_ZERO: assert (sel_vld || sel_idx == 5'd0); // R9
        AST_IDX_RANGE: assert (!sel_vld || sel_idx <= 5'd27); // R9
    end
endmodule

bind csr_gate csr_gate_chk i_chk (.*);

// File: tb/test_csr_gate.sv
module test_csr_gate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr  = '0;
    logic [1:0]  cur_priv  = '0;
    logic        is_write  = 1'b0;
    logic        xlat_trap = 1'b0;
    logic        acc_ok, acc_illegal, sel_vld;
    logic [4:0]  sel_idx;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    typedef struct {
        logic        ok;
        logic [4:0]  idx;
        logic [11:0] a;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_gate i_csr_gate (
        .csr_addr    (csr_addr),
        .cur_priv    (cur_priv),
        .is_write    (is_write),
        .xlat_trap   (xlat_trap),
        .acc_ok      (acc_ok),
        .acc_illegal (acc_illegal),
        .sel_vld     (sel_vld),
        .sel_idx     (sel_idx)
    );

    // reference model, written from the requirement lists
    function automatic bit in_mach_set(logic [11:0] a);
        return (a >= 12'hF11 && a <= 12'hF14) || (a >= 12'h300 && a <= 12'h306) ||
               (a >= 12'h340 && a <= 12'h344);
    endfunction

    function automatic bit in_sup_set(logic [11:0] a);
        return (a == 12'h100) || (a >= 12'h102 && a <= 12'h106) ||
               (a >= 12'h140 && a <= 12'h144) || (a == 12'h180);
    endfunction

    function automatic logic [4:0] ref_idx(logic [11:0] a);
        if (a >= 12'hF11 && a <= 12'hF14) return 5'(a - 12'hF11);
        if (a >= 12'h300 && a <= 12'h306) return 5'(4 + (a - 12'h300));
        if (a >= 12'h340 && a <= 12'h344) return 5'(11 + (a - 12'h340));
        if (a == 12'h100) return 5'd16;
        if (a >= 12'h102 && a <= 12'h106) return 5'(17 + (a - 12'h102));
        if (a >= 12'h140 && a <= 12'h144) return 5'(22 + (a - 12'h140));
        if (a == 12'h180) return 5'd27;
        return 5'd0;
    endfunction

    function automatic bit ref_ok(logic [11:0] a, logic [1:0] p, logic w, logic t);
        bit defd, ro, floor, trap;
        defd  = (in_mach_set(a) && p == 2'b11) || (in_sup_set(a) && (p == 2'b11 || p == 2'b01));
        ro    = w && (a[11:10] == 2'b11);
        floor = p >= a[9:8];
        trap  = (a == 12'h180) && (p == 2'b01) && t;
        return defd && !ro && floor && !trap;
    endfunction

    function automatic string pick_tag(logic [11:0] a, logic [1:0] p, logic w, logic t);
        if (a == 12'h180 && p == 2'b01 && t) return "R6";
        if (w && a[11:10] == 2'b11) return "R1";
        if (p == 2'b00 || p == 2'b10) return "R7";
        if (!in_mach_set(a) && !in_sup_set(a)) return "R5";
        if (p < a[9:8]) return "R2";
        if (in_mach_set(a)) return "R3";
        return "R4";
    endfunction

    // driver: apply one access at a rising edge and queue the expectation
    task automatic drive(logic [11:0] a, logic [1:0] p, logic w, logic t, string tag);
        exp_t e;
        @(posedge clk);
        csr_addr  <= a;
        cur_priv  <= p;
        is_write  <= w;
        xlat_trap <= t;
        e.ok  = ref_ok(a, p, w, t);
        e.idx = e.ok ? ref_idx(a) : 5'd0;
        e.a   = a;
        e.tag = (tag == "") ? pick_tag(a, p, w, t) : tag;
        sb_q.push_back(e);
    endtask

    // monitor: outputs are combinational, sample at the falling edge
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_total++;
            if (acc_ok !== e.ok || acc_illegal !== !e.ok) begin
                n_bad++;
                $display("FAIL %s addr=%h ok/illegal actual=%b/%b expected=%b/%b",
                         e.tag, e.a, acc_ok, acc_illegal, e.ok, !e.ok);
            end
            n_total++;
            if (sel_vld !== e.ok || sel_idx !== e.idx) begin
                n_bad++;
                $display("FAIL R9 (%s) addr=%h sel actual=%b/%0d expected=%b/%0d",
                         e.tag, e.a, sel_vld, sel_idx, e.ok, e.idx);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R7 / R8: idle inputs (address 0, user) give a denial with no select
        n_total++;
        if (acc_ok !== 1'b0 || acc_illegal !== 1'b1 || sel_vld !== 1'b0 || sel_idx !== 5'd0) begin
            n_bad++;
            $display("FAIL R7 idle state actual=%b%b%b/%0d expected=0110/0",
                     acc_ok, acc_illegal, sel_vld, sel_idx);
        end

        // directed cases
        drive(12'hF11, 2'b11, 1'b0, 1'b0, "R3");  // machine read of info reg, index 0
        drive(12'hF14, 2'b11, 1'b1, 1'b0, "R1");  // write to read-only is denied
        drive(12'hF12, 2'b01, 1'b1, 1'b0, "R1");  // read-only + floor + table collide
        drive(12'h300, 2'b11, 1'b1, 1'b0, "R3");  // machine write allowed, index 4
        drive(12'h306, 2'b01, 1'b0, 1'b0, "R2");  // supervisor below floor
        drive(12'h344, 2'b11, 1'b1, 1'b1, "R10"); // trap bit ignored, index 15
        drive(12'h100, 2'b01, 1'b1, 1'b1, "R10"); // trap bit ignored, index 16
        drive(12'h101, 2'b11, 1'b0, 1'b0, "R5");  // hole in supervisor span
        drive(12'h307, 2'b11, 1'b0, 1'b0, "R5");
        drive(12'hF15, 2'b11, 1'b0, 1'b0, "R5");
        drive(12'h180, 2'b01, 1'b0, 1'b0, "R6");  // allowed, index 27
        drive(12'h180, 2'b01, 1'b0, 1'b1, "R6");  // trapped
        drive(12'h180, 2'b01, 1'b1, 1'b1, "R6");  // trapped write
        drive(12'h180, 2'b11, 1'b1, 1'b1, "R6");  // machine unaffected
        drive(12'h144, 2'b01, 1'b1, 1'b0, "R4");  // index 26
        drive(12'h104, 2'b00, 1'b0, 1'b0, "R7");  // user denied
        drive(12'h104, 2'b10, 1'b0, 1'b0, "R7");  // reserved code denied

        // full sweep, trap bit toggling with address and write
        for (int a = 0; a < 4096; a++) begin
            for (int p = 0; p < 4; p++) begin
                for (int w = 0; w < 2; w++) begin
                    drive(12'(a), 2'(p), 1'(w), 1'(a[0] ^ w[0] ^ p[1]), "");
                end
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (WATCHDOG_CYC) @(posedge clk);
                n_total++;
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule